// File: doc/BRIEF.md
# Parallel Link Byte Sender

This block takes bytes from a local valid/ready stream and sends them one at a time over an 8-bit unidirectional parallel link to a receiver. The sender owns the data wires and an active-low strobe. The receiver answers on two wires, an acknowledge and an optional busy. Both come from another clock domain, so each passes through a multi-stage synchroniser before the control logic sees it.

For each byte the sender drives the data wires first. It waits a programmable setup time, then pulls the strobe low. It keeps the strobe low until it sees the synchronised acknowledge, then releases it. The data stays unchanged for a programmable hold time after the release. It accepts no new byte while either acknowledge or busy is still asserted. A receiver that never drives busy can leave that wire tied low.

If no acknowledge arrives within a programmable number of cycles, the sender releases the strobe, returns to idle and raises a timeout flag. The flag stays set until reset.

Top module: `pport_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `lnk_strobe_n` is 1, `timeout_flag` is 0, `lnk_data` is 0x00 and, with `lnk_ack` and `lnk_busy` low, `in_ready` is 1.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. That byte appears on `lnk_data` after that edge and stays there until the next accepted byte.
- R3: After an accept, `lnk_strobe_n` stays 1 for exactly SETUP_CYC cycles, then goes to 0.
- R4: `lnk_strobe_n` stays 0 until `lnk_ack` is seen through a two-flop synchroniser. If `lnk_ack` rises just before rising edge k, the strobe is still 0 after edges k and k+1 and is 1 after edge k+2.
- R5: For HOLD_CYC cycles after the strobe returns to 1, `in_ready` is 0 and `lnk_data` does not change.
- R6: If the strobe has been 0 for TIMEOUT_CYC cycles with no synchronised acknowledge, the strobe returns to 1 and the block goes back to idle. `timeout_flag` becomes 1 and stays 1 until reset.
- R7: `in_ready` is 1 only when the block is idle and both the synchronised acknowledge and the synchronised busy are 0. Each input is seen two rising edges after it changes.
- R8: A receiver that keeps `lnk_busy` at 0 at all times still completes every transfer.
- R9: `in_valid` asserted while `in_ready` is 0 has no effect: `lnk_data` and the strobe are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte offered by the local stream |
| in_valid | input | 1 | Local stream has a byte |
| in_ready | output | 1 | Sender is idle and the link is quiet |
| lnk_data | output | 8 | Parallel data wires to the receiver |
| lnk_strobe_n | output | 1 | Active-low strobe to the receiver |
| lnk_ack | input | 1 | Receiver acknowledge, asynchronous, active high |
| lnk_busy | input | 1 | Receiver busy, asynchronous, active high, may be tied low |
| timeout_flag | output | 1 | Sticky flag: an acknowledge did not arrive in time |

## Verification
The acknowledge and the timeout limit can fall due in the same cycle. So can a lingering acknowledge or busy and a new byte offered at the end of the hold time. The bench provokes the second case by holding `in_valid` high across back-to-back bytes while the receiver keeps busy high for a few cycles after dropping acknowledge. It then checks that no accept happens until both synchronised wires are low. A silent receiver exercises the timeout path, and a cycle-accurate model judges every cycle of `in_ready`, strobe, data and flag against these requirements.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } pp_state_e;

    typedef struct packed {
        logic ack;
        logic busy;
    } pp_lines_t;

    localparam int unsigned PP_LINE_W = $bits(pp_lines_t);

    function automatic int unsigned pp_max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned pp_cnt_width(int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pport_cnt.sv
module pport_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] last,
    output logic          at_last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == last);
endmodule

// File: rtl/pport_fsm.sv
module pport_fsm
    import pport_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned CW          = 4,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned HOLD_CYC    = 2,
    parameter int unsigned TIMEOUT_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  pp_lines_t     lines_s,
    input  logic          at_last,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic [CW-1:0] cnt_last,
    output logic [DW-1:0] lnk_data,
    output logic          lnk_strobe_n,
    output logic          timeout_flag
);
    localparam logic [CW-1:0] LAST_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LAST_HOLD  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LAST_TO    = CW'(TIMEOUT_CYC - 1);

    pp_state_e     st_q, st_d;
    logic [DW-1:0] data_q;
    logic          to_q, to_set;
    logic          quiet, accept;

    assign quiet    = !lines_s.ack && !lines_s.busy;
    assign in_ready = (st_q == ST_IDLE) && quiet;
    assign accept   = in_ready && in_valid;

    always_comb begin
        st_d     = st_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        to_set   = 1'b0;
        cnt_last = LAST_SETUP;
        unique case (st_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                if (accept) st_d = ST_SETUP;
            end
            ST_SETUP: begin
                cnt_last = LAST_SETUP;
                if (at_last) begin
                    st_d    = ST_STROBE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_STROBE: begin
                cnt_last = LAST_TO;
                if (lines_s.ack) begin
                    st_d    = ST_HOLD;
                    cnt_clr = 1'b1;
                end else if (at_last) begin
                    st_d    = ST_IDLE;
                    cnt_clr = 1'b1;
                    to_set  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_HOLD: begin
                cnt_last = LAST_HOLD;
                if (at_last) begin
                    st_d    = ST_IDLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
            to_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) data_q <= in_data;
            if (to_set) to_q   <= 1'b1;
        end
    end

    assign lnk_data     = data_q;
    assign lnk_strobe_n = (st_q != ST_STROBE);
    assign timeout_flag = to_q;
endmodule

// File: rtl/pport_tx.sv
module pport_tx
    import pport_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned HOLD_CYC    = 2,
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [DW-1:0] lnk_data,
    output logic          lnk_strobe_n,
    input  logic          lnk_ack,
    input  logic          lnk_busy,
    output logic          timeout_flag
);
    localparam int unsigned CNT_MAX = pp_max3(SETUP_CYC, HOLD_CYC, TIMEOUT_CYC);
    localparam int unsigned CW      = pp_cnt_width(CNT_MAX);

    pp_lines_t     lines_raw, lines_s;
    logic          ack_s, busy_s;
    logic          cnt_clr, cnt_inc, at_last;
    logic [CW-1:0] cnt_last;

    assign lines_raw = '{ack: lnk_ack, busy: lnk_busy};

    pport_sync #(.W(PP_LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_raw),
        .q   (lines_s)
    );

    assign ack_s  = lines_s.ack;
    assign busy_s = lines_s.busy;

    pport_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .last    (cnt_last),
        .at_last (at_last)
    );

    pport_fsm #(
        .DW          (DW),
        .CW          (CW),
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .lines_s      (lines_s),
        .at_last      (at_last),
        .cnt_clr      (cnt_clr),
        .cnt_inc      (cnt_inc),
        .cnt_last     (cnt_last),
        .lnk_data     (lnk_data),
        .lnk_strobe_n (lnk_strobe_n),
        .timeout_flag (timeout_flag)
    );
endmodule

// File: rtl/pport_tx_chk.sv
module pport_tx_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] in_data,
    input logic          in_valid,
    input logic          in_ready,
    input logic [DW-1:0] lnk_data,
    input logic          lnk_strobe_n,
    input logic          ack_s,
    input logic          busy_s,
    input logic          timeout_flag
);
    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (lnk_data == $past(in_data)) && !in_ready); // R2

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> lnk_strobe_n); // R3

    AST_DATA_STABLE_UNDER_STROBE: assert property (@(posedge clk) disable iff (rst)
        !lnk_strobe_n |-> $stable(lnk_data)); // R3

    AST_ACK_RELEASES_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!lnk_strobe_n && ack_s) |=> lnk_strobe_n); // R4

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        timeout_flag |=> timeout_flag); // R6

    AST_READY_LINES_QUIET: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!ack_s && !busy_s && lnk_strobe_n)); // R7

    AST_BLOCKED_VALID_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> $stable(lnk_data)); // R9
endmodule

bind pport_tx pport_tx_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .lnk_data     (lnk_data),
    .lnk_strobe_n (lnk_strobe_n),
    .ack_s        (ack_s),
    .busy_s       (busy_s),
    .timeout_flag (timeout_flag)
);

// File: tb/pport_tx_test.sv
module pport_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP_C    = 3;
    localparam int HOLD_C     = 2;
    localparam int TO_C       = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready, lnk_strobe_n, timeout_flag;
    logic [7:0] lnk_data;
    logic       lnk_ack, lnk_busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int       ms = 0, mcnt = 0, acc_cnt = 0;
    logic [7:0] mdata = 8'h00;
    bit       mto = 0, ma1 = 0, ma2 = 0, mb1 = 0, mb2 = 0;

    // receiver emulation
    bit s_mute = 0, s_busy_en = 0, s_ack = 0, s_busy = 0, force_busy = 0;
    int s_lat = 2, s_tail_len = 0, s_tail = 0, s_low = 0, ack_age = 0;
    logic [7:0] sent_q[$];
    int rx_cnt = 0;

    // measurement
    int seen_acc = 0, setup_run = -1, hold_left = 0;
    bit prev_strobe_n = 1;
    logic [7:0] hold_data;

    assign lnk_ack  = s_ack;
    assign lnk_busy = s_busy | force_busy;

    pport_tx #(.SETUP_CYC(SETUP_C), .HOLD_CYC(HOLD_C), .TIMEOUT_CYC(TO_C)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .lnk_data(lnk_data), .lnk_strobe_n(lnk_strobe_n),
        .lnk_ack(lnk_ack), .lnk_busy(lnk_busy), .timeout_flag(timeout_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ms = 0; mcnt = 0; mdata = 8'h00; mto = 0;
            ma1 = 0; ma2 = 0; mb1 = 0; mb2 = 0;
        end else begin
            case (ms)
                0: if (in_valid && !ma2 && !mb2) begin
                       ms = 1; mcnt = 0; mdata = in_data; acc_cnt++;
                   end
                1: if (mcnt == SETUP_C-1) begin ms = 2; mcnt = 0; end else mcnt++;
                2: if (ma2) begin ms = 3; mcnt = 0; end
                   else if (mcnt == TO_C-1) begin ms = 0; mcnt = 0; mto = 1; end
                   else mcnt++;
                default: if (mcnt == HOLD_C-1) begin ms = 0; mcnt = 0; end else mcnt++;
            endcase
            ma2 = ma1; ma1 = lnk_ack;
            mb2 = mb1; mb1 = lnk_busy;
        end
    end

    // compare, measure, then move the receiver, all away from the rising edge
    always @(negedge clk) begin
        // per-cycle comparison against the model
        check(in_ready === (ms == 0 && !ma2 && !mb2), "R7 ready", in_ready, (ms == 0 && !ma2 && !mb2));
        check(lnk_strobe_n === (ms != 2), "R4 strobe", lnk_strobe_n, (ms != 2));
        check(lnk_data === mdata, "R2 data", lnk_data, mdata);
        check(timeout_flag === mto, "R6 flag", timeout_flag, mto);

        if (!rst) begin
            // R3: count strobe-high cycles after each accept
            if (acc_cnt != seen_acc) begin seen_acc = acc_cnt; setup_run = 0; end
            if (setup_run >= 0) begin
                if (lnk_strobe_n) setup_run++;
                else begin
                    check(setup_run == SETUP_C, "R3 setup length", setup_run, SETUP_C);
                    setup_run = -1;
                end
            end
            // R5: hold window after strobe release (not after a timeout)
            if (!prev_strobe_n && lnk_strobe_n && !s_mute) begin
                hold_left = HOLD_C; hold_data = lnk_data;
            end
            if (hold_left > 0) begin
                check(!in_ready && lnk_data == hold_data, "R5 hold", {in_ready, lnk_data}, {1'b0, hold_data});
                hold_left--;
            end
            prev_strobe_n = lnk_strobe_n;
            // R4: strobe release latency after acknowledge
            if (s_ack) begin
                ack_age++;
                if (ack_age == 2) check(lnk_strobe_n == 1'b0, "R4 still low", lnk_strobe_n, 0);
                if (ack_age == 3) check(lnk_strobe_n == 1'b1, "R4 released", lnk_strobe_n, 1);
            end
        end

        // receiver
        if (!rst && !s_mute && !lnk_strobe_n && !s_ack) begin
            s_low++;
            if (s_low >= s_lat) begin
                s_ack = 1; ack_age = 0;
                if (s_busy_en) s_busy = 1;
                if (sent_q.size() > 0) begin
                    logic [7:0] e;
                    e = sent_q.pop_front();
                    check(lnk_data == e, "R2 byte received", lnk_data, e);
                end
                rx_cnt++;
            end
        end
        if (lnk_strobe_n) s_low = 0;
        if (s_ack && lnk_strobe_n) begin s_ack = 0; s_tail = s_tail_len; end
        else if (!s_ack && s_tail > 0) s_tail--;
        if (!s_ack && s_tail == 0) s_busy = 0;
    end

    task automatic send(input logic [7:0] b);
        int start;
        @(negedge clk);
        start = acc_cnt;
        in_valid = 1'b1; in_data = b;
        sent_q.push_back(b);
        while (acc_cnt == start) @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle_cycles(3);
        check(lnk_strobe_n && in_ready && !timeout_flag && lnk_data == 8'h00, "R1 in reset",
              {lnk_strobe_n, in_ready, timeout_flag}, 3'b110);
        rst = 1'b0;
        idle_cycles(1);
        check(lnk_strobe_n && in_ready && !timeout_flag && lnk_data == 8'h00, "R1 after reset",
              {lnk_strobe_n, in_ready, timeout_flag}, 3'b110);

        // busy never driven (R8)
        s_busy_en = 0; s_lat = 2;
        send(8'hA5); send(8'h3C); send(8'hFF); send(8'h00);
        idle_cycles(20);
        check(rx_cnt == 4, "R8 transfers without busy", rx_cnt, 4);

        // busy lingering after acknowledge, back-to-back offers (R7)
        s_busy_en = 1; s_tail_len = 5; s_lat = 4;
        send(8'h12); send(8'h34); send(8'h56);
        idle_cycles(25);
        check(rx_cnt == 7, "R7 transfers with busy", rx_cnt, 7);

        // offer while receiver holds busy: ignored (R9)
        force_busy = 1; idle_cycles(4);
        in_valid = 1'b1; in_data = 8'hEE;
        idle_cycles(6);
        check(lnk_data == 8'h56 && lnk_strobe_n && !in_ready, "R9 blocked offer ignored",
              lnk_data, 8'h56);
        in_valid = 1'b0; force_busy = 0;
        idle_cycles(4);
        check(in_ready == 1'b1, "R7 ready after busy drops", in_ready, 1);

        // silent receiver: timeout (R6)
        s_mute = 1; s_busy_en = 0; s_tail_len = 0;
        send(8'h77);
        void'(sent_q.pop_back());
        idle_cycles(SETUP_C + TO_C + 4);
        check(timeout_flag && lnk_strobe_n && in_ready, "R6 timeout", {timeout_flag, lnk_strobe_n}, 2'b11);

        // recovery, flag stays set
        s_mute = 0; s_lat = 1;
        send(8'h81);
        idle_cycles(20);
        check(rx_cnt == 8 && timeout_flag, "R6 sticky after recovery", rx_cnt, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected run end", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule